// File: doc/BRIEF.md
# Dynamic Priority Interrupt Sorter

This block chooses, for each of two interrupt classes, the single most urgent active line out of up to three banks of 32 lines and turns it into a numeric line code. The normal class and the fast class are searched in parallel and each keeps its own code register. A line competes in a class when it is pending, not masked, and steered to that class. Among the competitors the smallest priority number wins; equal priorities resolve in favour of the larger line number.

A surrounding controller pulses a per-class load strobe at the moment it is allowed to raise a new interrupt for that class. The search result is captured into that class's code register on the clock edge that samples the strobe, so the code is stable from the next cycle on. One cycle later a single-cycle done pulse is raised, letting the controller assert its parent output together with a code that has already settled. The number of populated banks is a parameter; lines in unpopulated banks are never chosen.

Top module: `psort_top`

## Requirements
- R1: A line is a candidate for the normal class when its pending bit is 1, its mask bit is 0 and its steering bit is 0; for the fast class the steering bit must be 1 instead. Non-candidates are never reported.
- R2: Among candidates of a class, the line with the numerically smallest priority value is chosen (0 is the most urgent).
- R3: When several candidates share the smallest priority, the one with the highest line number is chosen.
- R4: The reported code is 32 times the bank index plus the bit position inside that bank, i.e. the flat line index over the concatenated input vectors (bank 0 in bits 31:0).
- R5: When a class has no candidate at the moment its strobe is sampled, its code register is loaded with 0.
- R6: The two classes are searched and captured independently; a strobe for one class never alters the other class's code or done pulse, and both strobes may arrive in the same cycle.
- R7: A code register changes only on a clock edge that samples its class's load strobe high; otherwise it holds its value.
- R8: Lines whose bank index is not below ACTIVE_BANKS are never candidates, whatever their pending, mask, steering and priority inputs.
- R9: The code is valid one cycle after the strobe is sampled, and the class's done output is high for exactly the following cycle (two cycles after the strobe edge).
- R10: After reset both codes are 0 and both done outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | 96 | Pending vector, bank b in bits 32b+31:32b |
| mask_i | input | 96 | Mask vector, 1 blocks the line |
| steer_i | input | 96 | Class steering, 1 = fast class, 0 = normal class |
| prio_i | input | 576 | Per-line priority, line n in bits 6n+5:6n |
| load_irq_i | input | 1 | Capture strobe for the normal class |
| load_fiq_i | input | 1 | Capture strobe for the fast class |
| irq_code_o | output | 7 | Captured normal-class line code |
| fiq_code_o | output | 7 | Captured fast-class line code |
| irq_done_o | output | 1 | Normal-class result-ready pulse |
| fiq_done_o | output | 1 | Fast-class result-ready pulse |

## Verification
The two capture paths can fire in the same cycle, and one class can capture while the inputs that only the other class sees are changing. The bench pulses both strobes together and each one alone while lines are steered to both classes, and a behavioural model judges every cycle that each code register and done pulse moves only for its own strobe and holds the value its own search produced.

// File: rtl/psort_pkg.sv
package psort_pkg;
    localparam int unsigned LINES_PER_BANK = 32;
    localparam int unsigned NUM_CLASSES    = 2;

    typedef enum logic {
        CLS_NORMAL = 1'b0,
        CLS_FAST   = 1'b1
    } cls_e;
endpackage

// File: rtl/psort_cand.sv
module psort_cand
    import psort_pkg::*;
#(
    parameter int unsigned MAX_BANKS    = 3,
    parameter int unsigned ACTIVE_BANKS = 3,
    parameter bit          FAST_CLASS   = 1'b0,
    localparam int unsigned NL          = MAX_BANKS * LINES_PER_BANK
) (
    input  logic [NL-1:0] pend,
    input  logic [NL-1:0] mask,
    input  logic [NL-1:0] steer,
    output logic [NL-1:0] cand
);
    logic [NL-1:0] present;

    for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
        if (b < ACTIVE_BANKS) begin : g_on
            assign present[b*LINES_PER_BANK +: LINES_PER_BANK] = '1;
        end else begin : g_off
            assign present[b*LINES_PER_BANK +: LINES_PER_BANK] = '0;
        end
    end

    always_comb begin
        cand = pend & ~mask & present & (FAST_CLASS ? steer : ~steer);
    end
endmodule

// File: rtl/psort_tree.sv
module psort_tree #(
    parameter int unsigned NL     = 96,
    parameter int unsigned PW     = 6,
    localparam int unsigned CW    = $clog2(NL),
    localparam int unsigned LEAVES = 1 << $clog2(NL)
) (
    input  logic [NL-1:0]    cand,
    input  logic [NL*PW-1:0] prio,
    output logic             found,
    output logic [CW-1:0]    code
);
    logic          nv [LEAVES];
    logic [PW-1:0] np [LEAVES];
    logic [CW-1:0] nc [LEAVES];

    always_comb begin
        for (int i = 0; i < LEAVES; i++) begin
            if (i < NL) begin
                nv[i] = cand[i];
                np[i] = prio[i*PW +: PW];
            end else begin
                nv[i] = 1'b0;
                np[i] = '1;
            end
            nc[i] = CW'(i);
        end
        for (int w = LEAVES / 2; w > 0; w = w / 2) begin
            for (int j = 0; j < w; j++) begin
                if (nv[2*j+1] && (!nv[2*j] || (np[2*j+1] <= np[2*j]))) begin
                    nv[j] = 1'b1;
                    np[j] = np[2*j+1];
                    nc[j] = nc[2*j+1];
                end else begin
                    nv[j] = nv[2*j];
                    np[j] = np[2*j];
                    nc[j] = nc[2*j];
                end
            end
        end
        found = nv[0];
        code  = nc[0];
    end
endmodule

// File: rtl/psort_top.sv
module psort_top
    import psort_pkg::*;
#(
    parameter int unsigned MAX_BANKS    = 3,
    parameter int unsigned ACTIVE_BANKS = 3,
    parameter int unsigned PW           = 6,
    localparam int unsigned NL          = MAX_BANKS * LINES_PER_BANK,
    localparam int unsigned CW          = $clog2(NL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NL-1:0]    pend_i,
    input  logic [NL-1:0]    mask_i,
    input  logic [NL-1:0]    steer_i,
    input  logic [NL*PW-1:0] prio_i,
    input  logic             load_irq_i,
    input  logic             load_fiq_i,
    output logic [CW-1:0]    irq_code_o,
    output logic [CW-1:0]    fiq_code_o,
    output logic             irq_done_o,
    output logic             fiq_done_o
);
    typedef struct packed {
        logic [NUM_CLASSES-1:0][CW-1:0] code;
        logic [NUM_CLASSES-1:0]         seen;
        logic [NUM_CLASSES-1:0]         done;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_CLASSES-1:0]         load;
    logic [NUM_CLASSES-1:0]         sel_found;
    logic [NUM_CLASSES-1:0][CW-1:0] sel_code;

    assign load[CLS_NORMAL] = load_irq_i;
    assign load[CLS_FAST]   = load_fiq_i;

    for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_cls
        logic [NL-1:0] cand;

        psort_cand #(
            .MAX_BANKS   (MAX_BANKS),
            .ACTIVE_BANKS(ACTIVE_BANKS),
            .FAST_CLASS  (g == CLS_FAST)
        ) cand_i (
            .pend (pend_i),
            .mask (mask_i),
            .steer(steer_i),
            .cand (cand)
        );

        psort_tree #(
            .NL(NL),
            .PW(PW)
        ) tree_i (
            .cand (cand),
            .prio (prio_i),
            .found(sel_found[g]),
            .code (sel_code[g])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int g = 0; g < NUM_CLASSES; g++) begin
            if (load[g]) begin
                st_d.code[g] = sel_found[g] ? sel_code[g] : '0;
            end
            st_d.seen[g] = load[g];
            st_d.done[g] = st_q.seen[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_code_o = st_q.code[CLS_NORMAL];
    assign fiq_code_o = st_q.code[CLS_FAST];
    assign irq_done_o = st_q.done[CLS_NORMAL];
    assign fiq_done_o = st_q.done[CLS_FAST];
endmodule

// File: rtl/psort_chk.sv
module psort_chk #(
    parameter int unsigned MAX_BANKS    = 3,
    parameter int unsigned ACTIVE_BANKS = 3,
    parameter int unsigned PW           = 6,
    localparam int unsigned NL          = MAX_BANKS * 32,
    localparam int unsigned CW          = $clog2(NL)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NL-1:0]    pend_i,
    input logic [NL-1:0]    mask_i,
    input logic [NL-1:0]    steer_i,
    input logic [NL*PW-1:0] prio_i,
    input logic             load_irq_i,
    input logic             load_fiq_i,
    input logic [CW-1:0]    irq_code_o,
    input logic [CW-1:0]    fiq_code_o,
    input logic             irq_done_o,
    input logic             fiq_done_o
);
    logic [NL-1:0] live;
    logic [NL-1:0] irq_cand, fiq_cand;
    logic [NL-1:0] irq_cand_q, fiq_cand_q;
    logic          unused_prio;

    assign live        = {NL{1'b1}} >> (NL - ACTIVE_BANKS * 32);
    assign irq_cand    = pend_i & ~mask_i & ~steer_i & live;
    assign fiq_cand    = pend_i & ~mask_i & steer_i & live;
    assign unused_prio = ^prio_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_cand_q <= '0;
            fiq_cand_q <= '0;
        end else begin
            irq_cand_q <= irq_cand;
            fiq_cand_q <= fiq_cand;
        end
    end

    // R1, R8: a nonzero captured code names a line that was a live candidate
    a_r1_irq_is_cand: assert property (@(posedge clk) disable iff (!rst_n)
        load_irq_i |=> (irq_code_o == '0) || irq_cand_q[irq_code_o]);
    a_r1_fiq_is_cand: assert property (@(posedge clk) disable iff (!rst_n)
        load_fiq_i |=> (fiq_code_o == '0) || fiq_cand_q[fiq_code_o]);

    // R5: no candidate gives code 0
    a_r5_irq_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (load_irq_i && (irq_cand == '0)) |=> (irq_code_o == '0));
    a_r5_fiq_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fiq_i && (fiq_cand == '0)) |=> (fiq_code_o == '0));

    // R7: hold without strobe
    a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_irq_i |=> $stable(irq_code_o));
    a_r7_fiq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_fiq_i |=> $stable(fiq_code_o));

    // R9: done two cycles after the strobe edge
    a_r9_irq_done: assert property (@(posedge clk) disable iff (!rst_n)
        load_irq_i |=> ##1 irq_done_o);
    a_r9_fiq_done: assert property (@(posedge clk) disable iff (!rst_n)
        load_fiq_i |=> ##1 fiq_done_o);
endmodule

bind psort_top psort_chk #(
    .MAX_BANKS   (MAX_BANKS),
    .ACTIVE_BANKS(ACTIVE_BANKS),
    .PW          (PW)
) chk_i (.*);

// File: tb/psort_top_tb_top.sv
module psort_top_tb_top;
    localparam int MAXB = 3;
    localparam int ACT  = 2;
    localparam int PW   = 6;
    localparam int NL   = MAXB * 32;
    localparam int CW   = $clog2(NL);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NL-1:0]    pend = '0, mask = '0, steer = '0;
    logic [NL*PW-1:0] prio = '0;
    logic             ld_irq = 1'b0, ld_fiq = 1'b0;
    logic [CW-1:0]    irq_code, fiq_code;
    logic             irq_done, fiq_done;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    ended  = 1'b0;
    string cur_req = "R10";

    int exp_irq = 0, exp_fiq = 0;
    bit seen_irq = 0, seen_fiq = 0, exp_idone = 0, exp_fdone = 0;

    always #2 clk = ~clk;

    psort_top #(.MAX_BANKS(MAXB), .ACTIVE_BANKS(ACT), .PW(PW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .pend_i(pend), .mask_i(mask), .steer_i(steer), .prio_i(prio),
        .load_irq_i(ld_irq), .load_fiq_i(ld_fiq),
        .irq_code_o(irq_code), .fiq_code_o(fiq_code),
        .irq_done_o(irq_done), .fiq_done_o(fiq_done)
    );

    function automatic int pick(bit fast);
        int best = 1000;
        int res  = 0;
        for (int i = 0; i < ACT * 32; i++) begin
            if (pend[i] && !mask[i] && (steer[i] == fast) && (int'(prio[i*PW +: PW]) <= best)) begin
                best = int'(prio[i*PW +: PW]);
                res  = i;
            end
        end
        return res;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_irq <= 0; exp_fiq <= 0;
            seen_irq <= 0; seen_fiq <= 0; exp_idone <= 0; exp_fdone <= 0;
        end else begin
            if (ld_irq) exp_irq <= pick(1'b0);
            if (ld_fiq) exp_fiq <= pick(1'b1);
            seen_irq <= ld_irq; seen_fiq <= ld_fiq;
            exp_idone <= seen_irq; exp_fdone <= seen_fiq;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !ended) begin
            chk(cur_req, "model irq_code", int'(irq_code), exp_irq);
            chk(cur_req, "model fiq_code", int'(fiq_code), exp_fiq);
            chk("R9", "model irq_done", int'(irq_done), int'(exp_idone));
            chk("R9", "model fiq_done", int'(fiq_done), int'(exp_fdone));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !ended) begin
            ended = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=50000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic clear();
        pend = '0; mask = '0; steer = '0;
        for (int i = 0; i < NL; i++) prio[i*PW +: PW] = PW'(10);
    endtask

    task automatic setp(int line, int val);
        prio[line*PW +: PW] = PW'(val);
    endtask

    task automatic pulse(bit i, bit f);
        ld_irq = i; ld_fiq = f;
        @(negedge clk);
        ld_irq = 1'b0; ld_fiq = 1'b0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        clear();
        repeat (3) @(negedge clk);
        chk("R10", "reset irq_code", int'(irq_code), 0);
        chk("R10", "reset fiq_code", int'(fiq_code), 0);
        chk("R10", "reset irq_done", int'(irq_done), 0);
        chk("R10", "reset fiq_done", int'(fiq_done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R1";
        clear(); pend[5] = 1; pend[9] = 1; mask[9] = 1; pend[12] = 1; steer[12] = 1;
        pulse(1, 1);
        chk("R1", "irq_code", int'(irq_code), 5);
        chk("R1", "fiq_code", int'(fiq_code), 12);
        idle(2);

        cur_req = "R5";
        clear(); pend[9] = 1; mask[9] = 1;
        pulse(1, 1);
        chk("R5", "irq_code", int'(irq_code), 0);
        chk("R5", "fiq_code", int'(fiq_code), 0);
        idle(2);

        cur_req = "R2";
        clear(); pend[3] = 1; setp(3, 1); pend[40] = 1; setp(40, 0);
        pulse(1, 0);
        chk("R2", "irq_code", int'(irq_code), 40);
        clear(); pend[50] = 1; setp(50, 7); pend[2] = 1; setp(2, 4);
        pulse(1, 0);
        chk("R2", "irq_code", int'(irq_code), 2);
        idle(2);

        cur_req = "R3";
        clear(); pend[7] = 1; pend[20] = 1; pend[33] = 1;
        setp(7, 3); setp(20, 3); setp(33, 3);
        pulse(1, 0);
        chk("R3", "irq_code", int'(irq_code), 33);
        idle(2);

        cur_req = "R4";
        clear(); pend[63] = 1; pend[32] = 1; steer[32] = 1;
        pulse(1, 1);
        chk("R4", "irq_code", int'(irq_code), 63);
        chk("R4", "fiq_code", int'(fiq_code), 32);
        idle(2);

        cur_req = "R7";
        clear(); pend[1] = 1; pend[45] = 1; steer[45] = 1;
        idle(3);
        chk("R7", "irq_code", int'(irq_code), 63);
        chk("R7", "fiq_code", int'(fiq_code), 32);

        cur_req = "R6";
        pulse(1, 0);
        chk("R6", "irq_code", int'(irq_code), 1);
        chk("R6", "fiq_code", int'(fiq_code), 32);
        pulse(0, 1);
        chk("R6", "irq_code", int'(irq_code), 1);
        chk("R6", "fiq_code", int'(fiq_code), 45);
        idle(2);

        cur_req = "R8";
        clear(); pend[70] = 1; setp(70, 0); pend[1] = 1; setp(1, 9);
        pulse(1, 0);
        chk("R8", "irq_code", int'(irq_code), 1);
        clear(); pend[80] = 1; setp(80, 0); pend[90] = 1; steer[90] = 1;
        pulse(1, 1);
        chk("R8", "irq_code", int'(irq_code), 0);
        chk("R8", "fiq_code", int'(fiq_code), 0);
        idle(2);

        cur_req = "R9";
        clear(); pend[6] = 1;
        pulse(1, 0);
        chk("R9", "irq_done one cycle after strobe", int'(irq_done), 0);
        @(negedge clk);
        chk("R9", "irq_done two cycles after strobe", int'(irq_done), 1);
        chk("R9", "fiq_done stays low", int'(fiq_done), 0);
        @(negedge clk);
        chk("R9", "irq_done falls", int'(irq_done), 0);

        cur_req = "R2 R3 R6 random";
        for (int n = 0; n < 400; n++) begin
            pend  = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
            mask  = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
            steer = {$urandom, $urandom, $urandom};
            for (int i = 0; i < NL; i++) prio[i*PW +: PW] = PW'($urandom_range(0, 7));
            ld_irq = ($urandom_range(0, 2) == 0);
            ld_fiq = ($urandom_range(0, 2) == 0);
            @(negedge clk);
        end
        ld_irq = 1'b0; ld_fiq = 1'b0;
        idle(3);

        ended = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule